// File: doc/BRIEF.md
# Line-Interface Status and Event Register

This block gathers the health indications of a T1/E1 line interface into one 8-bit status byte. Five of the bits are condition bits: loss of the transmit clock, transmit open circuit, transmit current limit, receive carrier loss and input level under threshold. Each condition bit latches a 1 when its condition begins and again when it ends, so software learns of both transitions. The other three bits are event bits. They capture a jitter-buffer near-limit trip, a receive signaling change of state, and a periodic timer tick derived from the receive clock.

Every bit is sticky. A read returns the byte and clears all bits. A set that happens in the same cycle as a read wins, so no event is lost. The transmit clock is watched by a counter on the free-running system clock, so the loss is still seen when the transmit clock stops. The level-under-threshold input must hold for a persistence window before it counts as a condition. Both the timer interval and that window are measured in receive-clock cycles, and their lengths depend on the framing mode. All discrete condition and event inputs are synchronous to `clk`. The two line clocks are synchronised inside the block.

Top module: `lsr_line_status`

## Requirements
- R1: During and after reset all eight bits of `rd_data` are 0. The bit positions are: 7 level under threshold, 6 timer, 5 signaling change, 4 jitter trip, 3 carrier loss, 2 current limit, 1 open circuit, 0 transmit clock loss.
- R2: The bit for `open_ckt`, `cur_lim` or `carrier_loss` sets on every rising and every falling edge of that input. A level that holds steady after a read sets nothing. The current-limit bit follows `cur_lim` and does not depend on whether the limiter is enabled.
- R3: A cycle with `rd_en` high clears every bit, except that a bit whose set condition occurs in that same cycle stays 1.
- R4: With `rd_en` low, no bit that is 1 returns to 0.
- R5: Bit 0 sets once `txclk_in` has shown no transition for CHAN_BITS*TX_PERIOD_SYS system cycles. It sets again when transitions resume.
- R6: Bit 4 sets on a rising edge of `jit_near`. A level held high after a read does not set it again, and a falling edge does not set it.
- R7: A cycle with `sig_cos` high sets bit 5.
- R8: Bit 6 sets once every N rising edges of `rxclk_in`. N is TMR_T1_LONG, TMR_T1_SHORT, TMR_E1_LONG or TMR_E1_SHORT, chosen by `mode_e1` (1 = E1) and `short_intv` (1 = short).
- R9: Bit 7 sets when `level_low` has stayed high for HOLD_T1 (or HOLD_E1 when `mode_e1` = 1) rising edges of `rxclk_in` without a break. It sets again when `level_low` falls after qualifying. A break before the count is reached sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst | input | 1 | synchronous active-high reset |
| txclk_in | input | 1 | transmit line clock, asynchronous |
| rxclk_in | input | 1 | receive line clock, asynchronous |
| mode_e1 | input | 1 | 1 = E1 framing, 0 = T1 |
| short_intv | input | 1 | 1 = short timer interval |
| open_ckt | input | 1 | transmit open-circuit flag |
| cur_lim | input | 1 | transmit current-limit tripped flag |
| carrier_loss | input | 1 | receive carrier lost flag |
| level_low | input | 1 | raw input level below threshold |
| jit_near | input | 1 | jitter buffer near its limit |
| sig_cos | input | 1 | signaling change-of-state pulse |
| rd_en | input | 1 | register read strobe |
| rd_data | output | 8 | status byte |

## Verification
On every cycle, the assertions check the reset value, stickiness without a read, the edge-triggered setting of the open-circuit and carrier-loss bits, and the jitter-trip rising edge. They also check that a signaling pulse sets its bit even when it coincides with a read. The timing-based bits cannot be checked that way and are left to the bench's scenarios. These are the transmit-clock loss window, the four timer intervals counted in receive-clock edges, and the persistence window on level-under-threshold together with its break and release cases. A random phase then mixes reads with edges on the condition and event inputs against a reference model.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int unsigned STAT_W = 8;

    // Bit order is part of the register's meaning: MSB first.
    typedef struct packed {
        logic lvl_low;
        logic timer;
        logic sig_chg;
        logic jit_trip;
        logic carrier;
        logic cur_lim;
        logic open_ckt;
        logic tx_loss;
    } stat_t;

    // Condition vector index used for double-edge detection.
    typedef enum logic [2:0] {
        C_TXLOSS  = 3'd0,
        C_OPEN    = 3'd1,
        C_CURLIM  = 3'd2,
        C_CARRIER = 3'd3,
        C_LVL     = 3'd4
    } cond_idx_e;

    localparam int unsigned NUM_COND = 5;

    function automatic int unsigned pick_count(
        input logic        e1,
        input logic        short_sel,
        input int unsigned t1_long,
        input int unsigned t1_short,
        input int unsigned e1_long,
        input int unsigned e1_short
    );
        if (e1) return short_sel ? e1_short : e1_long;
        else    return short_sel ? t1_short : t1_long;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic lvl,
    output logic lvl_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            lvl_d <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            lvl_d <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/lsr_txclk_monitor.sv
module lsr_txclk_monitor #(
    parameter int unsigned LOSS_CYC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_change,
    output logic loss
);
    localparam int unsigned CW = $clog2(LOSS_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || tx_change) idle_cnt <= '0;
        else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign loss = (idle_cnt == LIMIT);
endmodule

// File: rtl/lsr_interval_timer.sv
module lsr_interval_timer
    import lsr_pkg::*;
#(
    parameter int unsigned T1_LONG  = 1544000,
    parameter int unsigned T1_SHORT = 64848,
    parameter int unsigned E1_LONG  = 2048000,
    parameter int unsigned E1_SHORT = 128000
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_rise,
    input  logic mode_e1,
    input  logic short_sel,
    output logic tick
);
    localparam int unsigned MAXC = max2(max2(T1_LONG, T1_SHORT), max2(E1_LONG, E1_SHORT));
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = CW'(pick_count(mode_e1, short_sel, T1_LONG, T1_SHORT, E1_LONG, E1_SHORT) - 1);
    // >= lets a switch to a shorter interval wrap at once
    assign tick = rx_rise && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tick)    cnt <= '0;
        else if (rx_rise) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lsr_persist_qual.sv
module lsr_persist_qual
    import lsr_pkg::*;
#(
    parameter int unsigned HOLD_T1 = 77200,
    parameter int unsigned HOLD_E1 = 102400
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    input  logic rx_rise,
    input  logic mode_e1,
    output logic qual
);
    localparam int unsigned CW = $clog2(max2(HOLD_T1, HOLD_E1) + 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] hold;

    assign hold = mode_e1 ? CW'(HOLD_E1) : CW'(HOLD_T1);
    assign qual = (run_cnt >= hold);

    always_ff @(posedge clk) begin
        if (rst || !level_in)       run_cnt <= '0;
        else if (rx_rise && !qual)  run_cnt <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/lsr_status_bits.sv
module lsr_status_bits #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= set_vec[i] | (q[i] & ~rd_clr);
        end
    end
endmodule

// File: rtl/lsr_line_status.sv
module lsr_line_status
    import lsr_pkg::*;
#(
    parameter int unsigned CHAN_BITS     = 8,
    parameter int unsigned TX_PERIOD_SYS = 16,
    parameter int unsigned TMR_T1_LONG   = 1544000,
    parameter int unsigned TMR_T1_SHORT  = 64848,
    parameter int unsigned TMR_E1_LONG   = 2048000,
    parameter int unsigned TMR_E1_SHORT  = 128000,
    parameter int unsigned HOLD_T1       = 77200,
    parameter int unsigned HOLD_E1       = 102400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txclk_in,
    input  logic              rxclk_in,
    input  logic              mode_e1,
    input  logic              short_intv,
    input  logic              open_ckt,
    input  logic              cur_lim,
    input  logic              carrier_loss,
    input  logic              level_low,
    input  logic              jit_near,
    input  logic              sig_cos,
    input  logic              rd_en,
    output logic [STAT_W-1:0] rd_data
);
    localparam int unsigned LOSS_CYC = CHAN_BITS * TX_PERIOD_SYS;

    logic tx_l, tx_ld, rx_l, rx_ld;
    logic tx_change, rx_rise;
    logic tx_loss, lvl_qual, tmr_tick;

    lsr_sync u_tx_sync (.clk(clk), .rst(rst), .async_in(txclk_in), .lvl(tx_l), .lvl_d(tx_ld));
    lsr_sync u_rx_sync (.clk(clk), .rst(rst), .async_in(rxclk_in), .lvl(rx_l), .lvl_d(rx_ld));

    assign tx_change = tx_l ^ tx_ld;
    assign rx_rise   = rx_l & ~rx_ld;

    lsr_txclk_monitor #(.LOSS_CYC(LOSS_CYC)) u_txmon (
        .clk(clk), .rst(rst), .tx_change(tx_change), .loss(tx_loss)
    );

    lsr_interval_timer #(
        .T1_LONG(TMR_T1_LONG), .T1_SHORT(TMR_T1_SHORT),
        .E1_LONG(TMR_E1_LONG), .E1_SHORT(TMR_E1_SHORT)
    ) u_timer (
        .clk(clk), .rst(rst), .rx_rise(rx_rise), .mode_e1(mode_e1),
        .short_sel(short_intv), .tick(tmr_tick)
    );

    lsr_persist_qual #(.HOLD_T1(HOLD_T1), .HOLD_E1(HOLD_E1)) u_lvl (
        .clk(clk), .rst(rst), .level_in(level_low), .rx_rise(rx_rise),
        .mode_e1(mode_e1), .qual(lvl_qual)
    );

    // Double-edge detection on the condition inputs
    logic [NUM_COND-1:0] cond, cond_prev, cond_edge;
    logic                jit_prev;

    always_comb begin
        cond            = '0;
        cond[C_TXLOSS]  = tx_loss;
        cond[C_OPEN]    = open_ckt;
        cond[C_CURLIM]  = cur_lim;
        cond[C_CARRIER] = carrier_loss;
        cond[C_LVL]     = lvl_qual;
    end

    // Previous values track the inputs through reset so release creates no edge
    always_ff @(posedge clk) begin
        cond_prev <= cond;
        jit_prev  <= jit_near;
    end

    assign cond_edge = cond ^ cond_prev;

    stat_t set_s;
    always_comb begin
        set_s.lvl_low  = cond_edge[C_LVL];
        set_s.timer    = tmr_tick;
        set_s.sig_chg  = sig_cos;
        set_s.jit_trip = jit_near & ~jit_prev;
        set_s.carrier  = cond_edge[C_CARRIER];
        set_s.cur_lim  = cond_edge[C_CURLIM];
        set_s.open_ckt = cond_edge[C_OPEN];
        set_s.tx_loss  = cond_edge[C_TXLOSS];
    end

    lsr_status_bits #(.W(STAT_W)) u_bits (
        .clk(clk), .rst(rst), .set_vec(set_s), .rd_clr(rd_en), .q(rd_data)
    );
endmodule

// File: rtl/lsr_line_status_chk.sv
module lsr_line_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       open_ckt,
    input logic       carrier_loss,
    input logic       jit_near,
    input logic       sig_cos,
    input logic       rd_en,
    input logic [7:0] rd_data
);
    // R1
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (rd_data == 8'h00));

    // R4
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R2
    a_r2_open_edge: assert property (@(posedge clk) disable iff (rst)
        (open_ckt != $past(open_ckt)) |=> rd_data[1]);

    // R2
    a_r2_carrier_edge: assert property (@(posedge clk) disable iff (rst)
        (carrier_loss != $past(carrier_loss)) |=> rd_data[3]);

    // R6
    a_r6_jit_rise: assert property (@(posedge clk) disable iff (rst)
        (jit_near && !$past(jit_near)) |=> rd_data[4]);

    // R7
    a_r7_sig_set: assert property (@(posedge clk) disable iff (rst)
        sig_cos |=> rd_data[5]);

    // R3
    a_r3_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sig_cos) |=> !rd_data[5]);
endmodule

bind lsr_line_status lsr_line_status_chk u_chk (
    .clk(clk), .rst(rst), .open_ckt(open_ckt), .carrier_loss(carrier_loss),
    .jit_near(jit_near), .sig_cos(sig_cos), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/tb_lsr_line_status.sv
`timescale 1ns/1ps
module tb_lsr_line_status;
    localparam int unsigned T1L = 40, T1S = 12, E1L = 50, E1S = 16;
    localparam int unsigned H_T1 = 6, H_E1 = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txclk_in = 1'b0, rxclk_in = 1'b0;
    logic mode_e1 = 1'b0, short_intv = 1'b0;
    logic open_ckt = 1'b0, cur_lim = 1'b0, carrier_loss = 1'b0, level_low = 1'b0;
    logic jit_near = 1'b0, sig_cos = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;

    int total = 0, bad = 0;
    bit tx_run = 1'b1;
    bit done = 1'b0;
    int unsigned tcnt = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    lsr_line_status #(
        .CHAN_BITS(8), .TX_PERIOD_SYS(4),
        .TMR_T1_LONG(T1L), .TMR_T1_SHORT(T1S), .TMR_E1_LONG(E1L), .TMR_E1_SHORT(E1S),
        .HOLD_T1(H_T1), .HOLD_E1(H_E1)
    ) dut (.*);

    // transmit clock: toggles every two system cycles while running
    initial forever begin
        @(negedge clk); @(negedge clk);
        if (tx_run) txclk_in = ~txclk_in;
    end

    function automatic int unsigned lim_of(input logic e1, input logic sh);
        if (e1) return sh ? E1S : E1L;
        return sh ? T1S : T1L;
    endfunction

    // reference timer: returns 1 when this receive edge produces a tick
    function automatic bit tmodel_step();
        int unsigned l = lim_of(mode_e1, short_intv);
        if (tcnt >= l - 1) begin tcnt = 0; return 1'b1; end
        tcnt++;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        @(negedge clk);
        rd_en = 1'b1;
        val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rx_pulse();
        bit t;
        @(negedge clk);
        rxclk_in = 1'b1;
        t = tmodel_step();
        repeat (4) @(negedge clk);
        rxclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        idle(2);
        check("R1 during reset", rd_data, 8'h00);
        idle(2);
        rst = 1'b0;
        idle(3);
        check("R1 after reset", rd_data, 8'h00);

        // R2 current limit both edges
        cur_lim = 1'b1; idle(2);
        do_read(v); check("R2 cur_lim rise bit2", v & 8'h04, 8'h04);
        idle(2);
        do_read(v); check("R2 cur_lim held no reset", v & 8'h04, 8'h00);
        cur_lim = 1'b0; idle(2);
        do_read(v); check("R2 cur_lim fall bit2", v & 8'h04, 8'h04);
        open_ckt = 1'b1; carrier_loss = 1'b1; idle(2);
        do_read(v); check("R2 open+carrier rise", v, 8'h0A);
        open_ckt = 1'b0; carrier_loss = 1'b0; idle(2);
        // R4 sticky across idle cycles
        idle(10);
        do_read(v); check("R4 held until read", v, 8'h0A);

        // R6 jitter trip
        jit_near = 1'b1; idle(2);
        do_read(v); check("R6 jit rise", v, 8'h10);
        idle(3);
        do_read(v); check("R6 jit held high", v, 8'h00);
        jit_near = 1'b0; idle(3);
        do_read(v); check("R6 jit fall", v, 8'h00);

        // R7 and R3: event coincides with read
        @(negedge clk); rd_en = 1'b1; sig_cos = 1'b1;
        @(negedge clk); rd_en = 1'b0; sig_cos = 1'b0;
        do_read(v); check("R3 set wins over read / R7", v, 8'h20);
        do_read(v); check("R3 cleared by read", v, 8'h00);

        // R5 transmit clock loss
        tx_run = 1'b0; idle(20);
        do_read(v); check("R5 no loss yet", v & 8'h01, 8'h00);
        idle(25);
        do_read(v); check("R5 loss after window", v & 8'h01, 8'h01);
        tx_run = 1'b1; idle(10);
        do_read(v); check("R5 clock resumes", v & 8'h01, 8'h01);
        idle(5);
        do_read(v); check("R5 steady clock", v & 8'h01, 8'h00);

        // R9 level under threshold persistence, T1
        mode_e1 = 1'b0; level_low = 1'b1;
        for (int i = 0; i < H_T1 - 1; i++) rx_pulse();
        do_read(v); check("R9 T1 short of window", v & 8'h80, 8'h00);
        rx_pulse(); idle(2);
        do_read(v); check("R9 T1 qualified", v & 8'h80, 8'h80);
        level_low = 1'b0; idle(3);
        do_read(v); check("R9 release sets", v & 8'h80, 8'h80);
        level_low = 1'b1;
        for (int i = 0; i < 4; i++) rx_pulse();
        level_low = 1'b0; idle(2); level_low = 1'b1;
        for (int i = 0; i < 4; i++) rx_pulse();
        do_read(v); check("R9 interrupted run", v & 8'h80, 8'h00);
        level_low = 1'b0; idle(2);
        // E1 window
        mode_e1 = 1'b1; level_low = 1'b1;
        for (int i = 0; i < H_E1 - 1; i++) rx_pulse();
        do_read(v); check("R9 E1 short of window", v & 8'h80, 8'h00);
        rx_pulse(); idle(2);
        do_read(v); check("R9 E1 qualified", v & 8'h80, 8'h80);
        level_low = 1'b0; idle(3);
        do_read(v);

        // R8 timer intervals
        for (int c = 0; c < 4; c++) begin
            int unsigned k;
            mode_e1 = c[1]; short_intv = c[0];
            do_read(v);
            k = lim_of(mode_e1, short_intv);
            k = (tcnt >= k - 1) ? 1 : k - tcnt;
            for (int i = 0; i < int'(k) - 1; i++) rx_pulse();
            do_read(v); check("R8 before tick", v & 8'h40, 8'h00);
            rx_pulse();
            do_read(v); check("R8 tick", v & 8'h40, 8'h40);
            for (int i = 0; i < int'(lim_of(mode_e1, short_intv)) - 1; i++) rx_pulse();
            do_read(v); check("R8 full interval early", v & 8'h40, 8'h00);
            rx_pulse();
            do_read(v); check("R8 full interval tick", v & 8'h40, 8'h40);
        end

        // Random mix: R2 R3 R4 R6 R7
        begin
            logic [7:0] expv;
            logic po = 0, pc = 0, pl = 0, pj = 0;
            int unsigned seed;
            seed = $urandom(32'd1234);
            do_read(v);
            expv = 8'h00;
            for (int it = 0; it < 400; it++) begin
                logic r, no, nc, nl, nj, ns;
                logic [7:0] setv;
                @(negedge clk);
                check("R4/R3 random model", rd_data, expv);
                r  = ($urandom % 4) == 0;
                no = ($urandom % 5 == 0) ? ~po : po;
                nc = ($urandom % 5 == 0) ? ~pc : pc;
                nl = ($urandom % 5 == 0) ? ~pl : pl;
                nj = ($urandom % 4 == 0) ? ~pj : pj;
                ns = ($urandom % 6) == 0;
                rd_en = r; open_ckt = no; carrier_loss = nc; cur_lim = nl;
                jit_near = nj; sig_cos = ns;
                setv = {2'b00, ns, nj & ~pj, nc ^ pc, nl ^ pl, no ^ po, 1'b0};
                expv = (r ? 8'h00 : expv) | setv;
                po = no; pc = nc; pl = nl; pj = nj;
            end
            @(negedge clk);
            check("R2 random final", rd_data, expv);
            rd_en = 1'b0; sig_cos = 1'b0;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule